// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the parallel bus of a NOR-style flash model and the engines that program, erase and protect the array. It watches the chip-enable, write-enable and output-enable strobes and turns each qualified write cycle into one internal write event. A write only counts when its strobe stays asserted for a set number of clocks. The events go through a small sequencer that looks for unlock-prefixed multi-cycle commands: byte program, chip erase, boot-region lock enable, and entry to or exit from an identification mode.

When a full command has been seen, the block emits a one-clock start pulse. For a byte program it also presents the target address and data. A `busy` input from the operation engines freezes the sequencer while an operation runs. In identification mode, reads return fixed identification bytes and the boot-lock status in place of array data. Outside that mode the array data passes through unchanged.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `id_mode` is 0, no start pulse is asserted, and `rdata` equals `array_rdata`.
- R2: A write is accepted only while `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold for at least MIN_PULSE consecutive clocks (default 3). A shorter strobe, or one with `oe_n`=0, is ignored.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 followed by any write (A, D) produce one `prog_start` pulse with `op_addr`=A and `op_data`=D.
- R4: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555 produce one `erase_start` pulse.
- R5: The same six-write sequence ending in 0x40@0x5555 in place of 0x10 produces one `lock_start` pulse.
- R6: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555 set `id_mode`. In that mode a read at address 0 returns 0x1F, at 1 returns 0x22, and at 2 returns {7'b0, `lock_state`}. Every other address returns 0x00.
- R7: `id_mode` is cleared by the writes 0xAA@0x5555, 0x55@0x2AAA, 0xF0@0x5555, or by a single write of 0xF0 to any address while the sequencer is idle.
- R8: Only address bits [14:0] are compared during unlock and command steps. A write that does not match the expected step returns the sequencer to idle with no pulse, and the next correct sequence still works.
- R9: While `busy`=1, accepted writes are ignored: the sequencer state and `id_mode` do not change and no pulse follows. A sequence resumes where it stopped once `busy` drops.
- R10: At most one of the three start pulses is high in any cycle, and each pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW (20) | Bus address |
| wdata | input | 8 | Bus write data |
| busy | input | 1 | Operation engine running |
| lock_state | input | 1 | Current boot-region lock status |
| array_rdata | input | 8 | Read data from the array |
| rdata | output | 8 | Read data returned to the bus |
| id_mode | output | 1 | Identification mode active |
| prog_start | output | 1 | One-clock start of a byte program |
| erase_start | output | 1 | One-clock start of a chip erase |
| lock_start | output | 1 | One-clock start of boot-region lock enable |
| op_addr | output | AW (20) | Target address of the byte program |
| op_data | output | 8 | Data byte of the byte program |

## Verification
The assertions assume the bus strobes and `busy` are synchronous to `clk`. They also assume that `addr` and `wdata` hold steady for the whole time a write strobe is asserted, so the values captured on the qualifying clock are the intended ones. The stimulus changes every input only on falling clock edges. It holds address and data for the full strobe, inserts idle clocks between writes, and raises or lowers `busy` only between writes. The sweeps cover every value of the third command byte and every value of the sixth, plus noise-length strobes, strobes with output enable active, upper-address aliasing and mismatch recovery.

// File: rtl/nor_cmd_pkg.sv
// Package: shared constants and types for the flash command decoder.
// Assumes byte-wide bus data and 15-bit unlock address comparison.
package nor_cmd_pkg;
    localparam int DATA_W = 8;
    localparam int CMP_W  = 15;

    typedef logic [DATA_W-1:0] byte_t;

    localparam logic [CMP_W-1:0] KEY_ADR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADR_B = 15'h2AAA;
    localparam byte_t KEY_DAT_A  = 8'hAA;
    localparam byte_t KEY_DAT_B  = 8'h55;
    localparam byte_t OP_PROGRAM = 8'hA0;
    localparam byte_t OP_EXTEND  = 8'h80;
    localparam byte_t OP_ID_IN   = 8'h90;
    localparam byte_t OP_ID_OUT  = 8'hF0;
    localparam byte_t OP_ERASE   = 8'h10;
    localparam byte_t OP_LOCK    = 8'h40;

    typedef enum logic [2:0] {
        SQ_IDLE,   // waiting for first unlock write
        SQ_KEY1,   // first unlock write seen
        SQ_KEY2,   // second unlock write seen
        SQ_PROG,   // waiting for target address/data
        SQ_EXT1,   // extended command byte seen
        SQ_EXT2,   // second-round first unlock seen
        SQ_EXT3    // second-round second unlock seen
    } seq_state_t;
endpackage

// File: rtl/nor_wr_filter.sv
// Module: qualifies bus write strobes. A write is accepted when chip enable
// and write enable are low with output enable high for MIN_PULSE consecutive
// clocks; address and data are captured on that clock and presented with a
// one-cycle wr_vld the next cycle. Assumes synchronous strobes and MIN_PULSE >= 1.
module nor_wr_filter
    import nor_cmd_pkg::*;
#(
    parameter int AW        = 20,
    parameter int MIN_PULSE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  byte_t         wdata,
    output logic          wr_vld,
    output logic [AW-1:0] wr_addr,
    output byte_t         wr_data
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    logic          qual;
    logic          fire;
    logic [CW-1:0] hold_cnt;

    assign qual = !ce_n && !we_n && oe_n;
    assign fire = qual && (hold_cnt == CW'(MIN_PULSE - 1));

    // Count consecutive qualifying clocks, saturating once the write fired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (!qual)
            hold_cnt <= '0;
        else if (hold_cnt != CW'(MIN_PULSE))
            hold_cnt <= hold_cnt + 1'b1;
    end

    // Emit the accepted write and capture its address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_vld <= fire;
            if (fire) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
        end
    end

    // R2
    wr_after_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> $past(qual));
    // R2
    one_wr_per_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> !wr_vld);
endmodule

// File: rtl/nor_cmd_fsm.sv
// Module: command sequencer. Walks accepted writes through the unlock
// prefix and command bytes, raises one-cycle start pulses, latches the
// program target and tracks identification mode. Assumes wr_vld is a
// single-cycle event; busy freezes all state changes.
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vld,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic          busy,
    output logic          prog_start,
    output logic          erase_start,
    output logic          lock_start,
    output logic [AW-1:0] op_addr,
    output byte_t         op_data,
    output logic          id_mode
);
    seq_state_t state, state_nxt;
    logic       id_nxt, go_prog, go_erase, go_lock;
    logic       hit_a, hit_b, take;

    assign hit_a = wr_addr[CMP_W-1:0] == KEY_ADR_A;
    assign hit_b = wr_addr[CMP_W-1:0] == KEY_ADR_B;
    assign take  = wr_vld && !busy;

    // Next-state and command decode for one accepted write.
    always_comb begin
        state_nxt = state;
        id_nxt    = id_mode;
        go_prog   = 1'b0;
        go_erase  = 1'b0;
        go_lock   = 1'b0;
        if (take) begin
            state_nxt = SQ_IDLE;
            case (state)
                SQ_IDLE: begin
                    if (hit_a && wr_data == KEY_DAT_A) state_nxt = SQ_KEY1;
                    else if (wr_data == OP_ID_OUT)     id_nxt    = 1'b0;
                end
                SQ_KEY1: if (hit_b && wr_data == KEY_DAT_B) state_nxt = SQ_KEY2;
                SQ_KEY2: if (hit_a) begin
                    case (wr_data)
                        OP_PROGRAM: state_nxt = SQ_PROG;
                        OP_EXTEND:  state_nxt = SQ_EXT1;
                        OP_ID_IN:   id_nxt    = 1'b1;
                        OP_ID_OUT:  id_nxt    = 1'b0;
                        default:    state_nxt = SQ_IDLE;
                    endcase
                end
                SQ_PROG: go_prog = 1'b1;
                SQ_EXT1: if (hit_a && wr_data == KEY_DAT_A) state_nxt = SQ_EXT2;
                SQ_EXT2: if (hit_b && wr_data == KEY_DAT_B) state_nxt = SQ_EXT3;
                SQ_EXT3: if (hit_a) begin
                    go_erase = wr_data == OP_ERASE;
                    go_lock  = wr_data == OP_LOCK;
                end
                default: state_nxt = SQ_IDLE;
            endcase
        end
    end

    // Register sequencer state, mode flag and start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            id_mode     <= 1'b0;
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
            lock_start  <= 1'b0;
        end else begin
            state       <= state_nxt;
            id_mode     <= id_nxt;
            prog_start  <= go_prog;
            erase_start <= go_erase;
            lock_start  <= go_lock;
        end
    end

    // Latch the program target on the final program write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr <= '0;
            op_data <= '0;
        end else if (go_prog) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
        end
    end

    // R10
    start_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, erase_start, lock_start}));
    // R10
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || erase_start || lock_start) |=>
            !(prog_start || erase_start || lock_start));
    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && busy) |=> ($stable(state) && $stable(id_mode)));
    // R9
    busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && busy) |=> !(prog_start || erase_start || lock_start));
    // R3
    start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || erase_start || lock_start) |-> $past(wr_vld && !busy));
endmodule

// File: rtl/nor_id_mux.sv
// Module: read-data selector. In identification mode returns the
// manufacturer byte, device byte or lock status by address; otherwise
// passes array data through. Purely combinational.
module nor_id_mux
    import nor_cmd_pkg::*;
#(
    parameter int    AW      = 20,
    parameter byte_t MFR_ID  = 8'h1F,
    parameter byte_t DEV_ID  = 8'h22
) (
    input  logic          id_mode,
    input  logic [AW-1:0] addr,
    input  logic          lock_state,
    input  byte_t         array_rdata,
    output byte_t         rdata
);
    byte_t id_byte;

    // Select the identification byte for the read address.
    always_comb begin
        if (addr == AW'(0))      id_byte = MFR_ID;
        else if (addr == AW'(1)) id_byte = DEV_ID;
        else if (addr == AW'(2)) id_byte = {{(DATA_W-1){1'b0}}, lock_state};
        else                     id_byte = '0;
    end

    assign rdata = id_mode ? id_byte : array_rdata;
endmodule

// File: rtl/nor_cmd_decoder.sv
// Module: top of the flash command sequence decoder. Chains the write
// strobe filter, command sequencer and read selector. Assumes all bus
// inputs are synchronous to clk; reset is synchronous, active low.
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int    AW        = 20,
    parameter int    MIN_PULSE = 3,
    parameter byte_t MFR_ID    = 8'h1F,
    parameter byte_t DEV_ID    = 8'h22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          busy,
    input  logic          lock_state,
    input  logic [7:0]    array_rdata,
    output logic [7:0]    rdata,
    output logic          id_mode,
    output logic          prog_start,
    output logic          erase_start,
    output logic          lock_start,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_data
);
    logic          wr_vld;
    logic [AW-1:0] wr_addr;
    byte_t         wr_data;

    nor_wr_filter #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_filter (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    nor_cmd_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy),
        .prog_start(prog_start), .erase_start(erase_start),
        .lock_start(lock_start), .op_addr(op_addr), .op_data(op_data),
        .id_mode(id_mode)
    );

    nor_id_mux #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_mux (
        .id_mode(id_mode), .addr(addr), .lock_state(lock_state),
        .array_rdata(array_rdata), .rdata(rdata)
    );

    // R1
    array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> rdata == array_rdata);
    // R6
    id_mfr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && addr == AW'(0)) |-> rdata == MFR_ID);
    // R6
    id_lock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && addr == AW'(2)) |-> rdata[0] == lock_state);
endmodule

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;
    localparam int AW  = 20;
    localparam int MIN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          busy = 1'b0, lock_state = 1'b0;
    logic [7:0]    array_rdata;
    logic [7:0]    rdata, op_data;
    logic          id_mode, prog_start, erase_start, lock_start;
    logic [AW-1:0] op_addr;

    int checks = 0, errors = 0;
    int n_prog = 0, n_erase = 0, n_lock = 0, n_bad = 0;
    int e_prog = 0, e_erase = 0, e_lock = 0;
    logic [AW-1:0] last_a = '0;
    logic [7:0]    last_d = '0;
    logic          prev_any = 1'b0;

    always #10 clk = ~clk;
    assign array_rdata = addr[7:0] ^ 8'hC3;

    nor_cmd_decoder #(.AW(AW), .MIN_PULSE(MIN)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .busy(busy), .lock_state(lock_state),
        .array_rdata(array_rdata), .rdata(rdata), .id_mode(id_mode),
        .prog_start(prog_start), .erase_start(erase_start),
        .lock_start(lock_start), .op_addr(op_addr), .op_data(op_data)
    );

    // Pulse monitor, sampled away from the active edge (R10 bookkeeping).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_start) begin n_prog++; last_a = op_addr; last_d = op_data; end
            if (erase_start) n_erase++;
            if (lock_start) n_lock++;
            if ((32'(prog_start) + 32'(erase_start) + 32'(lock_start)) > 1) n_bad++;
            if (prev_any && (prog_start || erase_start || lock_start)) n_bad++;
            prev_any = prog_start || erase_start || lock_start;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input int n, input logic oe);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; oe_n = oe; we_n = 1'b0;
        repeat (n) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic w(input logic [AW-1:0] a, input logic [7:0] d);
        wr(a, d, MIN, 1'b1);
    endtask

    task automatic prefix();
        w(20'h05555, 8'hAA);
        w(20'h02AAA, 8'h55);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1 chk(rdata == exp, req, int'(rdata), int'(exp));
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic counts(input string req);
        chk(n_prog == e_prog, req, n_prog, e_prog);
        chk(n_erase == e_erase, req, n_erase, e_erase);
        chk(n_lock == e_lock, req, n_lock, e_lock);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(id_mode == 1'b0, "R1 id_mode", int'(id_mode), 0);
        rd(20'h00000, 8'hC3, "R1 rdata");
        counts("R1");

        // R3: basic byte program
        prefix(); w(20'h05555, 8'hA0); w(20'h7ABCD, 8'h3C); e_prog++;
        counts("R3 program");
        chk(last_a == 20'h7ABCD, "R3 op_addr", int'(last_a), 32'h7ABCD);
        chk(last_d == 8'h3C, "R3 op_data", int'(last_d), 32'h3C);

        // R4: chip erase; R5: lock enable
        prefix(); w(20'h05555, 8'h80); prefix(); w(20'h05555, 8'h10); e_erase++;
        counts("R4 erase");
        prefix(); w(20'h05555, 8'h80); prefix(); w(20'h05555, 8'h40); e_lock++;
        counts("R5 lock");

        // R6: identification reads
        prefix(); w(20'h05555, 8'h90);
        chk(id_mode == 1'b1, "R6 id entry", int'(id_mode), 1);
        rd(20'h00000, 8'h1F, "R6 mfr");
        rd(20'h00001, 8'h22, "R6 dev");
        lock_state = 1'b0; rd(20'h00002, 8'h00, "R6 lock0");
        lock_state = 1'b1; rd(20'h00002, 8'h01, "R6 lock1");
        rd(20'h00003, 8'h00, "R6 other");
        rd(20'h10000, 8'h00, "R6 high");

        // R7: single-write exit, then three-write exit
        w(20'h12345, 8'hF0);
        chk(id_mode == 1'b0, "R7 single exit", int'(id_mode), 0);
        rd(20'h00000, 8'hC3, "R7 array back");
        prefix(); w(20'h05555, 8'h90);
        chk(id_mode == 1'b1, "R7 reentry", int'(id_mode), 1);
        prefix(); w(20'h05555, 8'hF0);
        chk(id_mode == 1'b0, "R7 prefixed exit", int'(id_mode), 0);

        // R8: upper address bits ignored
        w(20'h3D555, 8'hAA); w(20'hA2AAA, 8'h55); w(20'hF5555, 8'hA0);
        w(20'h00042, 8'h99); e_prog++;
        counts("R8 alias");
        chk(last_d == 8'h99, "R8 alias data", int'(last_d), 32'h99);
        // R8: bit 14 differs, wrong second address, wrong key data
        w(20'h01555, 8'hAA); w(20'h02AAA, 8'h55); w(20'h05555, 8'hA0); w(20'h00010, 8'h11);
        w(20'h05555, 8'hAA); w(20'h06AAA, 8'h55); w(20'h05555, 8'hA0); w(20'h00010, 8'h11);
        w(20'h05555, 8'hAB); w(20'h02AAA, 8'h55); w(20'h05555, 8'hA0); w(20'h00010, 8'h11);
        prefix(); w(20'h05555, 8'h80); w(20'h05555, 8'h55); prefix(); w(20'h05555, 8'h10);
        counts("R8 mismatch");
        prefix(); w(20'h05555, 8'hA0); w(20'h00077, 8'h66); e_prog++;
        counts("R8 recovery");

        // R2: short strobe and output-enable-active strobe ignored
        wr(20'h05555, 8'hAA, MIN - 1, 1'b1);
        w(20'h02AAA, 8'h55); w(20'h05555, 8'hA0); w(20'h00020, 8'h22);
        counts("R2 short strobe");
        wr(20'h05555, 8'hAA, MIN + 2, 1'b0);
        w(20'h02AAA, 8'h55); w(20'h05555, 8'hA0); w(20'h00020, 8'h22);
        counts("R2 oe active");
        prefix(); w(20'h05555, 8'hA0);
        wr(20'h00031, 8'h31, MIN - 1, 1'b1);
        counts("R2 short data write");
        wr(20'h00032, 8'h32, MIN + 4, 1'b1); e_prog++;
        counts("R2 long strobe");
        chk(last_d == 8'h32, "R2 data", int'(last_d), 32'h32);

        // R9: busy freezes the sequence
        prefix(); w(20'h05555, 8'hA0);
        busy = 1'b1; w(20'h00050, 8'h50); busy = 1'b0;
        counts("R9 busy ignore");
        w(20'h00051, 8'h51); e_prog++;
        counts("R9 resume");
        chk(last_a == 20'h00051, "R9 addr", int'(last_a), 32'h51);
        busy = 1'b1; prefix(); w(20'h05555, 8'h90); busy = 1'b0;
        chk(id_mode == 1'b0, "R9 id held", int'(id_mode), 0);

        // R3/R6/R8: sweep of the third command byte
        for (int v = 0; v < 256; v++) begin
            prefix(); w(20'h05555, 8'(v)); w(20'h01234, 8'h5A);
            if (v == 8'hA0) e_prog++;
            chk(n_prog == e_prog, "R3 sweep3", n_prog, e_prog);
            chk(id_mode == (v == 8'h90), "R6 sweep3", int'(id_mode), int'(v == 8'h90));
            if (id_mode) w(20'h00000, 8'hF0);
        end
        counts("R8 sweep3");

        // R4/R5: sweep of the sixth command byte
        for (int v = 0; v < 256; v++) begin
            prefix(); w(20'h05555, 8'h80); prefix(); w(20'h05555, 8'(v));
            if (v == 8'h10) e_erase++;
            if (v == 8'h40) e_lock++;
            chk(n_erase == e_erase, "R4 sweep6", n_erase, e_erase);
            chk(n_lock == e_lock, "R5 sweep6", n_lock, e_lock);
        end
        chk(n_prog == e_prog, "R8 sweep6", n_prog, e_prog);

        // R10: pulse exclusivity and width
        chk(n_bad == 0, "R10 pulses", n_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule